// File: doc/BRIEF.md
# Parallel Converter Read Sequencer

This block is the host side of a 12-bit successive-approximation converter that has a parallel bus and a BUSY handshake. When a one-cycle trigger arrives, it first lowers the read/convert line. One cycle later it lowers chip select, which starts the conversion. Both lines are held low for a fixed number of cycles and then released. The block then waits for BUSY to return high, passing it through a synchronizer first. After that it reads the result back. The read is either one 12-bit word, or two 8-bit reads on the upper lane with the BYTE line toggled between them. Each read is sampled only after a bus access delay has passed. The result is a two's-complement value. It is sign-extended to 16 bits and presented together with a one-cycle valid strobe.

A watchdog limits how long the block waits for BUSY. If BUSY does not rise in time, an error flag is raised and the sequence is abandoned. A spacing timer starts when each convert pulse begins, and the next pulse cannot begin until it has run out. This guarantees the acquisition time the converter needs. Every width and delay is a parameter counted in clock cycles. The defaults assume a 100 MHz clock: a 5-cycle pulse, a 9-cycle access delay, 1000 cycles between conversions and a 2000-cycle timeout.

The sequencer is a Moore machine with these states:
- ST_IDLE leaves on a trigger.
- ST_SETUP lowers read/convert for one cycle.
- ST_PULSE holds chip select low.
- ST_WAIT either sees BUSY rise and goes to ST_ACCESS, or times out and goes to ST_GAP.
- ST_ACCESS goes to ST_BYTE2 in byte mode and to ST_DONE otherwise.
- ST_BYTE2 goes to ST_DONE.
- ST_DONE goes to ST_GAP.
- ST_GAP returns to ST_IDLE once the spacing timer is done.

Top module: `adc_par_reader`

## Requirements
- R1: While reset is asserted and right after it is released, chip select and read/convert are high, BYTE is low, the valid strobe and error flag are low, and the sample is zero.
- R2: A trigger accepted in ST_IDLE drives read/convert low one cycle before chip select falls. Both lines then stay low together for exactly PULSE_CYC cycles. With the default parameters this is at least 4 and at most 600 cycles, i.e. 40 ns to 6 µs.
- R3: At the end of the pulse, both control lines return high and stay high until BUSY has risen. Read/convert is therefore high whenever BUSY rises.
- R4: In word mode, chip select is held low with read/convert high and BYTE low for ACCESS_CYC cycles. Then the upper lane (result bits 11..4) and the top four bits of the lower lane (result bits 3..0) are captured.
- R5: In byte mode, a first read takes result bits 11..4 from the upper lane with BYTE low. A second read takes result bits 3..0 from the top four bits of the upper lane with BYTE high. Each read waits ACCESS_CYC cycles after its last control change. BYTE is high only while chip select is low.
- R6: The result appears as a 16-bit sign-extension of the 12-bit two's-complement code, with a valid strobe exactly one cycle long. The strobe comes SYNC_STAGES+1+ACCESS_CYC cycles after BUSY rises in word mode, and SYNC_STAGES+1+2*ACCESS_CYC cycles after in byte mode.
- R7: If BUSY has not risen within TIMEOUT_CYC cycles of the pulse ending, the error flag rises at exactly that cycle and no valid strobe is produced. The flag clears when the next trigger is accepted.
- R8: Consecutive convert pulses begin at least SPACING_CYC cycles apart. With the trigger held high, each new pulse begins exactly SPACING_CYC+2 cycles after the previous one.
- R9: A trigger outside ST_IDLE starts no pulse and does not alter the read in progress.
- R10: The byte-mode input is sampled only when a trigger is accepted. Changing it later has no effect on that transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Conversion trigger |
| byte_mode_i | input | 1 | 1 = two-byte read, 0 = word read |
| busy_i | input | 1 | Converter BUSY, high when idle |
| lane_hi_i | input | 8 | Upper data lane |
| lane_lo_i | input | 4 | Top four bits of the lower data lane |
| cs_n_o | output | 1 | Chip select, active low |
| rc_o | output | 1 | Read/convert, low = convert |
| byte_o | output | 1 | Lane select for byte reads |
| sample_o | output | 16 | Sign-extended result |
| sample_vld_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | BUSY timeout flag |

## Verification
The bench's converter model timestamps the negative edge at which it raises BUSY. It then expects the valid strobe exactly SYNC_STAGES+1+ACCESS_CYC cycles later, or twice the access term later in byte mode, and checks that the strobe is gone one cycle after that. The model drives filler on the bus until the control lines have been stable for ACCESS_CYC-1 observed cycles, so sampling one cycle early produces a wrong value. The error flag is checked to be low one cycle before the timeout cycle and high at it. Pulse width and pulse spacing are counted from the model's own timestamps of when both control lines are low.

// File: rtl/adc_pkg.sv
package adc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_PULSE,
        ST_WAIT,
        ST_ACCESS,
        ST_BYTE2,
        ST_DONE,
        ST_GAP
    } rd_state_t;

endpackage

// File: rtl/adc_sync.sv
module adc_sync #(
    parameter int  STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            for (int i = STAGES - 1; i > 0; i--) begin
                chain_q[i] <= chain_q[i-1];
            end
            chain_q[0] <= d_i;
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/adc_cnt.sv
module adc_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/adc_par_reader.sv
module adc_par_reader
    import adc_pkg::*;
#(
    parameter int PULSE_CYC   = 5,
    parameter int ACCESS_CYC  = 9,
    parameter int SPACING_CYC = 1000,
    parameter int TIMEOUT_CYC = 2000,
    parameter int SYNC_STAGES = 2,
    parameter int RAW_W       = 12,
    parameter int LANE_W      = 8,
    parameter int SAMPLE_W    = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    byte_mode_i,
    input  logic                    busy_i,
    input  logic [LANE_W-1:0]       lane_hi_i,
    input  logic [RAW_W-LANE_W-1:0] lane_lo_i,
    output logic                    cs_n_o,
    output logic                    rc_o,
    output logic                    byte_o,
    output logic [SAMPLE_W-1:0]     sample_o,
    output logic                    sample_vld_o,
    output logic                    err_o
);

    localparam int NIB_W  = RAW_W - LANE_W;
    localparam int PH_M1  = (PULSE_CYC > ACCESS_CYC) ? PULSE_CYC : ACCESS_CYC;
    localparam int PH_MAX = (PH_M1 > TIMEOUT_CYC) ? PH_M1 : TIMEOUT_CYC;
    localparam int PH_W   = $clog2(PH_MAX + 1);
    localparam int GAP_W  = $clog2(SPACING_CYC + 1);
    localparam int EXT_W  = SAMPLE_W - RAW_W;

    rd_state_t st_q, st_nxt;

    logic             busy_s, busy_prev_q, busy_rise;
    logic             ph_load, ph_zero;
    logic [PH_W-1:0]  ph_val;
    logic             gap_load, gap_zero;
    logic             mode_q;
    logic             err_q, err_set, err_clr;
    logic             cap_hi, cap_lo;
    logic [RAW_W-1:0] raw_q;

    // BUSY crosses into the clock domain before edge detection
    adc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_busy_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (busy_i),
        .q_o  (busy_s)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) busy_prev_q <= 1'b1;
        else        busy_prev_q <= busy_s;
    end

    assign busy_rise = busy_s && !busy_prev_q;

    // phase timer: pulse width, access delay and BUSY watchdog share it
    adc_cnt #(.W(PH_W)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(ph_load),
        .val_i (ph_val),
        .zero_o(ph_zero)
    );

    // spacing timer: runs from the start of each convert pulse
    adc_cnt #(.W(GAP_W)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(gap_load),
        .val_i (GAP_W'(SPACING_CYC - 1)),
        .zero_o(gap_zero)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nxt;
    end

    // next state and timer control
    always_comb begin
        st_nxt   = st_q;
        ph_load  = 1'b0;
        ph_val   = '0;
        gap_load = 1'b0;
        err_set  = 1'b0;
        err_clr  = 1'b0;
        cap_hi   = 1'b0;
        cap_lo   = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (start_i) begin
                    st_nxt  = ST_SETUP;
                    err_clr = 1'b1;
                end
            end
            ST_SETUP: begin
                st_nxt   = ST_PULSE;
                ph_load  = 1'b1;
                ph_val   = PH_W'(PULSE_CYC - 1);
                gap_load = 1'b1;
            end
            ST_PULSE: begin
                if (ph_zero) begin
                    st_nxt  = ST_WAIT;
                    ph_load = 1'b1;
                    ph_val  = PH_W'(TIMEOUT_CYC - 1);
                end
            end
            ST_WAIT: begin
                if (busy_rise) begin
                    st_nxt  = ST_ACCESS;
                    ph_load = 1'b1;
                    ph_val  = PH_W'(ACCESS_CYC - 1);
                end else if (ph_zero) begin
                    st_nxt  = ST_GAP;
                    err_set = 1'b1;
                end
            end
            ST_ACCESS: begin
                if (ph_zero) begin
                    cap_hi = 1'b1;
                    if (mode_q) begin
                        st_nxt  = ST_BYTE2;
                        ph_load = 1'b1;
                        ph_val  = PH_W'(ACCESS_CYC - 1);
                    end else begin
                        st_nxt = ST_DONE;
                    end
                end
            end
            ST_BYTE2: begin
                if (ph_zero) begin
                    cap_lo = 1'b1;
                    st_nxt = ST_DONE;
                end
            end
            ST_DONE: st_nxt = ST_GAP;
            ST_GAP: begin
                if (gap_zero) st_nxt = ST_IDLE;
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // outputs decoded from the state alone
    always_comb begin
        cs_n_o       = 1'b1;
        rc_o         = 1'b1;
        byte_o       = 1'b0;
        sample_vld_o = 1'b0;
        unique case (st_q)
            ST_IDLE, ST_WAIT, ST_GAP: ;
            ST_SETUP:  rc_o = 1'b0;
            ST_PULSE: begin
                rc_o   = 1'b0;
                cs_n_o = 1'b0;
            end
            ST_ACCESS: cs_n_o = 1'b0;
            ST_BYTE2: begin
                cs_n_o = 1'b0;
                byte_o = 1'b1;
            end
            ST_DONE: sample_vld_o = 1'b1;
            default: ;
        endcase
    end

    // transaction mode, error flag and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            err_q  <= 1'b0;
            raw_q  <= '0;
        end else begin
            if (st_q == ST_IDLE && start_i) mode_q <= byte_mode_i;
            if (err_set)      err_q <= 1'b1;
            else if (err_clr) err_q <= 1'b0;
            if (cap_hi) begin
                raw_q[RAW_W-1:NIB_W] <= lane_hi_i;
                if (!mode_q) raw_q[NIB_W-1:0] <= lane_lo_i;
            end
            if (cap_lo) raw_q[NIB_W-1:0] <= lane_hi_i[LANE_W-1 -: NIB_W];
        end
    end

    assign err_o    = err_q;
    assign sample_o = {{EXT_W{raw_q[RAW_W-1]}}, raw_q};

endmodule

// File: rtl/adc_par_reader_chk.sv
module adc_par_reader_chk #(
    parameter int MIN_W   = 4,
    parameter int MAX_W   = 600,
    parameter int SPACING = 1000
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic rc,
    input logic byte_sel,
    input logic busy,
    input logic vld,
    input logic err
);

    logic        conv, conv_q, seen_q;
    logic [15:0] wcnt_q;
    logic [31:0] gap_q;

    assign conv = !cs_n && !rc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_q <= 1'b0;
            seen_q <= 1'b0;
            wcnt_q <= '0;
            gap_q  <= '0;
        end else begin
            conv_q <= conv;
            if (conv) wcnt_q <= (wcnt_q == 16'hFFFF) ? wcnt_q : wcnt_q + 1'b1;
            else      wcnt_q <= '0;
            if (conv && !conv_q) begin
                gap_q  <= 32'd1;
                seen_q <= 1'b1;
            end else if (gap_q != 32'hFFFF_FFFF) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    p_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n) && !rc) |-> $past(!rc));

    p_pulse_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv) |-> (wcnt_q >= 16'(MIN_W) && wcnt_q <= 16'(MAX_W)));

    p_rc_high_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> rc);

    p_byte_in_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_sel |-> (!cs_n && rc));

    p_vld_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vld |=> !vld);

    p_err_no_vld_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !vld);

    p_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (conv && !conv_q && seen_q) |-> (gap_q >= 32'(SPACING)));

endmodule

bind adc_par_reader adc_par_reader_chk #(.SPACING(SPACING_CYC)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n_o),
    .rc      (rc_o),
    .byte_sel(byte_o),
    .busy    (busy_i),
    .vld     (sample_vld_o),
    .err     (err_o)
);

// File: tb/tb_adc_par_reader.sv
module tb_adc_par_reader;

    localparam int PULSE = 5;
    localparam int ACC   = 9;
    localparam int SPACE = 1000;
    localparam int TMO   = 2000;
    localparam int SYNC  = 2;
    localparam int CONV  = 40;
    localparam int PMIN  = 4;
    localparam int PMAX  = 600;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        bmode = 1'b0;
    logic        busy = 1'b1;
    logic [7:0]  lane_hi = 8'h5A;
    logic [3:0]  lane_lo = 4'h5;
    logic        cs_n, rc, byte_sel, vld, err;
    logic [15:0] sample;

    always #5 clk = ~clk;

    adc_par_reader #(
        .PULSE_CYC(PULSE), .ACCESS_CYC(ACC), .SPACING_CYC(SPACE),
        .TIMEOUT_CYC(TMO), .SYNC_STAGES(SYNC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .byte_mode_i(bmode),
        .busy_i(busy), .lane_hi_i(lane_hi), .lane_lo_i(lane_lo),
        .cs_n_o(cs_n), .rc_o(rc), .byte_o(byte_sel), .sample_o(sample),
        .sample_vld_o(vld), .err_o(err)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit finished = 0;

    // converter model state
    bit          model_on = 1;
    logic [11:0] next_res = '0;
    logic [11:0] res_lat  = '0;
    int busy_rise_cyc = -1, pulse_cnt = 0, pulse_start = -1, prev_pulse_start = -1;
    int pulse_end = -1, pulse_w = 0, setup_bad = 0, rc_viol = 0, conv_left = 0, stab = 0;
    logic       conv_prev = 1'b0, rc_prev = 1'b1, cs_prev = 1'b1;
    logic [2:0] ctrl_prev = 3'b110;

    initial begin : converter_model
        forever begin
            logic conv_now;
            @(negedge clk);
            cyc++;
            conv_now = !cs_n && !rc;
            if (conv_left > 0) begin
                conv_left--;
                if (conv_left == 0) begin
                    res_lat       = next_res;
                    busy          = 1'b1;
                    busy_rise_cyc = cyc;
                    if (!rc) rc_viol++;
                end
            end
            if (conv_now && !conv_prev) begin
                pulse_cnt++;
                prev_pulse_start = pulse_start;
                pulse_start      = cyc;
                if (!(!rc_prev && cs_prev)) setup_bad++;
                pulse_w = 1;
                if (busy && model_on) begin
                    busy      = 1'b0;
                    conv_left = CONV;
                end
            end else if (conv_now) begin
                pulse_w++;
            end
            if (!conv_now && conv_prev) pulse_end = cyc;
            conv_prev = conv_now;
            rc_prev   = rc;
            cs_prev   = cs_n;
            if ({cs_n, rc, byte_sel} != ctrl_prev) stab = 0;
            else if (stab < 100000) stab++;
            ctrl_prev = {cs_n, rc, byte_sel};
            if (!cs_n && rc && stab >= ACC - 1) begin
                if (byte_sel) begin
                    lane_hi = {res_lat[3:0], 4'h0};
                    lane_lo = res_lat[11:8];
                end else begin
                    lane_hi = res_lat[11:4];
                    lane_lo = res_lat[3:0];
                end
            end else begin
                lane_hi = 8'h5A;
                lane_lo = 4'h5;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic pulse_trigger();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_vld(output int at, output logic [15:0] s);
        at = -1;
        s  = '0;
        for (int i = 0; i < 4000; i++) begin
            tick();
            if (vld) begin
                at = cyc;
                s  = sample;
                break;
            end
        end
    endtask

    task automatic run_conv(input bit bm, input logic [11:0] val, input string tag);
        int          at, lat;
        logic [15:0] s;
        next_res = val;
        bmode    = bm;
        pulse_trigger();
        bmode = !bm;                       // R10: late change must not matter
        wait_vld(at, s);
        lat = SYNC + 1 + ACC * (bm ? 2 : 1);
        check({tag, " R6 latency"}, at - busy_rise_cyc, lat);
        check({tag, " R6 sign-extended sample"}, int'(s), int'({{4{val[11]}}, val}));
        tick();
        check({tag, " R6 strobe one cycle"}, int'(vld), 0);
        check({tag, " R2 pulse width"}, pulse_w, PULSE);
        check({tag, " R2 width in range"}, int'(pulse_w >= PMIN && pulse_w <= PMAX), 1);
        check({tag, " R2 setup order"}, setup_bad, 0);
        check({tag, " R3 rc high at busy rise"}, rc_viol, 0);
        repeat (SPACE) tick();
    endtask

    task automatic t_reset();
        repeat (3) tick();
        check("R1 cs_n in reset", int'(cs_n), 1);
        check("R1 rc in reset", int'(rc), 1);
        check("R1 byte in reset", int'(byte_sel), 0);
        check("R1 vld/err in reset", int'({vld, err}), 0);
        check("R1 sample in reset", int'(sample), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) tick();
        check("R1 idle after reset", int'({cs_n, rc, byte_sel, vld, err}), 5'b11000);
    endtask

    task automatic t_word();
        run_conv(1'b0, 12'h7FF, "R4 word +fs");
        run_conv(1'b0, 12'h800, "R4 word -fs");
        run_conv(1'b0, 12'hABC, "R4 word neg");
    endtask

    task automatic t_byte();
        run_conv(1'b1, 12'h5A3, "R5 byte pos");
        run_conv(1'b1, 12'hF01, "R5 byte neg");
    endtask

    task automatic t_ignore();
        int          p0, at;
        logic [15:0] s;
        p0       = pulse_cnt;
        next_res = 12'h3C6;
        bmode    = 1'b0;
        pulse_trigger();
        repeat (12) tick();
        bmode = 1'b1;
        pulse_trigger();                   // R9: trigger while waiting for BUSY
        wait_vld(at, s);
        check("R9 read unaffected", int'(s), int'(16'h03C6));
        check("R10 word latency kept", at - busy_rise_cyc, SYNC + 1 + ACC);
        pulse_trigger();                   // R9: trigger during spacing
        repeat (SPACE + 20) tick();
        check("R9 single pulse", pulse_cnt - p0, 1);
    endtask

    task automatic t_timeout();
        int mark, ce, nv;
        model_on = 0;
        mark     = cyc;
        nv       = 0;
        pulse_trigger();
        while (pulse_end <= mark) tick();
        ce = pulse_end;
        while (cyc < ce + TMO - 1) begin
            tick();
            if (vld) nv++;
        end
        check("R7 no error before limit", int'(err), 0);
        tick();
        check("R7 error at limit", int'(err), 1);
        repeat (5) tick();
        if (vld) nv++;
        check("R7 no strobe on timeout", nv, 0);
        model_on = 1;
        repeat (SPACE) tick();
        pulse_trigger();
        tick();
        check("R7 error cleared by trigger", int'(err), 0);
        repeat (SPACE + 200) tick();
    endtask

    task automatic t_spacing();
        int p0;
        p0       = pulse_cnt;
        next_res = 12'h111;
        @(negedge clk);
        start = 1'b1;
        for (int i = 0; i < 5000 && pulse_cnt < p0 + 2; i++) tick();
        start = 1'b0;
        check("R8 spacing exact", pulse_start - prev_pulse_start, SPACE + 2);
        check("R8 spacing minimum", int'(pulse_start - prev_pulse_start >= SPACE), 1);
        repeat (SPACE + 50) tick();
    endtask

    initial begin : main
        t_reset();
        t_word();
        t_byte();
        t_ignore();
        t_timeout();
        t_spacing();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule